// File: doc/BRIEF.md
# Register-Memory Multi-Cycle Processor Core

This block is a small sequential processor. It executes three-address instructions that read from a code ROM. Each arithmetic instruction names two sources and one destination. Any of these operands may be an immediate, a register, or a word in data memory, so results can move from memory to memory without a separate load or store. The core also has a 16-entry register file, a move instruction, a zero-test relative branch, a branch through a register and a relative subroutine call that leaves a link value in a register.

One instruction runs as a series of phases: fetch, first source, second source, then execute and write-back. A phase that touches memory takes an extra cycle, because the single data port returns read data one cycle after the request. The host releases reset, pulses `start`, and waits for `halted`. The core stops when its program counter reaches or passes the program length. A later `start` runs the program again from address zero, with the registers and memory unchanged.

Top module: `qmc_core`

## Requirements
- R1: After reset `halted` is 1 and `dmem_re` and `dmem_we` stay 0 until `start` is pulsed.
- R2: A `start` pulse while halted sets the program counter to 0, and in the next cycle `imem_addr` presents 0 while `halted` is 0.
- R3: Opcode 0 multiplies, 1 adds and 2 subtracts (source 1 minus source 2). Results wrap modulo 2^32, the product keeps its low 32 bits, and the program counter then advances by one.
- R4: Word layout: opcode in bits 63:60, then the destination, source-1 and source-2 slots of 20 bits each, from bit 59 down. A slot holds mode[19:17], register[16:13] and a signed 13-bit field[12:0]. Source modes are: 0 sign-extended field; 1 register; 2 memory at the field; 3 memory at the register; 4 memory at the register plus the sign-extended field. Modes 5 to 7 act like mode 0.
- R5: Destination modes 1 to 4 write the register or the memory word that the same source mode would read. Destination modes 0 and 5 to 7 discard the result, with no memory write.
- R6: Opcode 3 copies source 1 to the destination. Source 2 is never read, even when its mode names memory.
- R7: Inside one instruction the memory accesses follow a fixed order: the source-1 read, then the source-2 read, then the destination write. Read data is taken one cycle after the request, and `dmem_re` and `dmem_we` are never high together.
- R8: Opcode 4 tests the source-1 register. If it is zero, pc becomes pc plus the sign-extended source-1 field. Otherwise pc becomes pc plus one.
- R9: Opcode 5 loads pc from the low 16 bits of the source-1 register.
- R10: Opcode 6 writes pc+1 into register 15 and sets pc to pc plus the sign-extended source-1 field.
- R11: When pc is at or above the program length at fetch, including a branch target that wrapped negative, the core halts. It then holds `halted` at 1 with no memory access.
- R12: Opcodes 7 to 15 change no register or memory, make no memory access, and advance pc by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse to begin execution at address 0 |
| imem_addr | output | PCW | Code ROM address (program counter) |
| imem_rdata | input | 64 | Instruction word, combinational from the ROM |
| dmem_re | output | 1 | Data memory read request |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_addr | output | AW | Data memory word address |
| dmem_wdata | output | DW | Data memory write data |
| dmem_rdata | input | DW | Read data, valid the cycle after `dmem_re` |
| halted | output | 1 | High while idle or stopped |

## Verification
The bench builds the core with 32-bit data, an 11-bit data address, a 16-bit program counter and a program length of 16. It also selects the shift-and-add multiplier variant, so the wrapping products are checked on the iterative structure and not only on the native operator. A length of 16 lets short programs run off their end through padding with undefined opcodes. The 16-bit counter lets a backward branch past zero wrap to a large value that must halt the core. The 11-bit address space holds the negative-offset indexed accesses and the logged order of reads and writes around one memory-to-memory instruction.

// File: rtl/qmc_pkg.sv
package qmc_pkg;
   localparam int OPC_W  = 4;
   localparam int MODE_W = 3;
   localparam int RIDX_W = 4;
   localparam int FLD_W  = 13;
   localparam int SLOT_W = MODE_W + RIDX_W + FLD_W;
   localparam int INSN_W = OPC_W + 3 * SLOT_W;

   localparam logic [OPC_W-1:0] OPC_MUL  = 4'd0;
   localparam logic [OPC_W-1:0] OPC_ADD  = 4'd1;
   localparam logic [OPC_W-1:0] OPC_SUB  = 4'd2;
   localparam logic [OPC_W-1:0] OPC_MOV  = 4'd3;
   localparam logic [OPC_W-1:0] OPC_BZ   = 4'd4;
   localparam logic [OPC_W-1:0] OPC_BREG = 4'd5;
   localparam logic [OPC_W-1:0] OPC_CALL = 4'd6;

   localparam logic [MODE_W-1:0] AM_IMM = 3'd0;
   localparam logic [MODE_W-1:0] AM_REG = 3'd1;
   localparam logic [MODE_W-1:0] AM_DIR = 3'd2;
   localparam logic [MODE_W-1:0] AM_IND = 3'd3;
   localparam logic [MODE_W-1:0] AM_IDX = 3'd4;

   typedef struct packed {
      logic [MODE_W-1:0] mode;
      logic [RIDX_W-1:0] ridx;
      logic [FLD_W-1:0]  fld;
   } slot_t;

   typedef struct packed {
      logic [OPC_W-1:0] opc;
      slot_t            dst;
      slot_t            s1;
      slot_t            s2;
   } insn_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_LD1, ST_WT1, ST_LD2, ST_WT2, ST_EXEC, ST_HALT
   } state_e;

   function automatic logic mode_is_mem(logic [MODE_W-1:0] m);
      return (m == AM_DIR) || (m == AM_IND) || (m == AM_IDX);
   endfunction

   function automatic logic opc_is_data(logic [OPC_W-1:0] o);
      return o <= OPC_MOV;
   endfunction
endpackage

// File: rtl/qmc_regfile.sv
module qmc_regfile #(
   parameter int IDXW = 4,
   parameter int DW   = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [IDXW-1:0] waddr,
   input  logic [DW-1:0]   wdata,
   input  logic [IDXW-1:0] raddr_a,
   output logic [DW-1:0]   rdata_a,
   input  logic [IDXW-1:0] raddr_b,
   output logic [DW-1:0]   rdata_b
);
   localparam int NREG = 1 << IDXW;

   if (IDXW < 1 || IDXW > 6) begin : g_chk_idxw
      $error("qmc_regfile: IDXW out of range");
   end

   logic [DW-1:0] regs [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (we) begin
         regs[waddr] <= wdata;
      end
   end

   assign rdata_a = regs[raddr_a];
   assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/qmc_agen.sv
module qmc_agen
   import qmc_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 11
) (
   input  slot_t          slot,
   input  logic [DW-1:0]  rval,
   output logic           is_mem,
   output logic [AW-1:0]  addr,
   output logic [DW-1:0]  imm
);
   if (DW < FLD_W || AW > DW) begin : g_chk_w
      $error("qmc_agen: need FLD_W <= DW and AW <= DW");
   end

   logic [DW-1:0] sum;

   assign imm    = {{(DW-FLD_W){slot.fld[FLD_W-1]}}, slot.fld};
   assign sum    = rval + imm;
   assign is_mem = mode_is_mem(slot.mode);

   always_comb begin
      case (slot.mode)
         AM_DIR:  addr = imm[AW-1:0];
         AM_IND:  addr = rval[AW-1:0];
         AM_IDX:  addr = sum[AW-1:0];
         default: addr = '0;
      endcase
   end
endmodule

// File: rtl/qmc_alu.sv
module qmc_alu
   import qmc_pkg::*;
#(
   parameter int DW          = 32,
   parameter int MUL_VARIANT = 0
) (
   input  logic [OPC_W-1:0] opc,
   input  logic [DW-1:0]    a,
   input  logic [DW-1:0]    b,
   output logic [DW-1:0]    y
);
   logic [DW-1:0] prod;

   if (MUL_VARIANT == 0) begin : g_mul_native
      assign prod = a * b;
   end else if (MUL_VARIANT == 1) begin : g_mul_shift
      always_comb begin
         prod = '0;
         for (int i = 0; i < DW; i++) begin
            if (b[i]) prod = prod + (a << i);
         end
      end
   end else begin : g_mul_bad
      $error("qmc_alu: MUL_VARIANT must be 0 or 1");
   end

   always_comb begin
      case (opc)
         OPC_MUL: y = prod;
         OPC_ADD: y = a + b;
         OPC_SUB: y = a - b;
         default: y = a;
      endcase
   end
endmodule

// File: rtl/qmc_core.sv
module qmc_core
   import qmc_pkg::*;
#(
   parameter int DW          = 32,
   parameter int AW          = 11,
   parameter int PCW         = 16,
   parameter int PROG_LEN    = 16,
   parameter int LINK_REG    = 15,
   parameter int MUL_VARIANT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic [PCW-1:0]    imem_addr,
   input  logic [INSN_W-1:0] imem_rdata,
   output logic              dmem_re,
   output logic              dmem_we,
   output logic [AW-1:0]     dmem_addr,
   output logic [DW-1:0]     dmem_wdata,
   input  logic [DW-1:0]     dmem_rdata,
   output logic              halted
);
   localparam int NREG = 1 << RIDX_W;

   if (PCW < FLD_W || PCW > DW) begin : g_chk_pcw
      $error("qmc_core: need FLD_W <= PCW <= DW");
   end
   if (PROG_LEN < 1 || PROG_LEN >= (1 << PCW)) begin : g_chk_len
      $error("qmc_core: PROG_LEN must fit the program counter");
   end
   if (LINK_REG < 0 || LINK_REG >= NREG) begin : g_chk_link
      $error("qmc_core: LINK_REG outside the register file");
   end

   state_e         st;
   logic [PCW-1:0] pc;
   insn_t          ir;
   insn_t          fetched;
   logic [DW-1:0]  op1, op2;

   slot_t          cur_slot;
   logic [DW-1:0]  rf_rd_a, rf_rd_b;
   logic           rf_we;
   logic [RIDX_W-1:0] rf_waddr;
   logic [DW-1:0]  rf_wdata;
   logic           ag_mem;
   logic [AW-1:0]  ag_addr;
   logic [DW-1:0]  ag_imm;
   logic [DW-1:0]  src_val;
   logic [DW-1:0]  alu_y;
   logic [PCW-1:0] pc_inc, br_off, pc_next;
   logic           is_data, is_mov;

   assign fetched = insn_t'(imem_rdata);
   assign is_data = opc_is_data(ir.opc);
   assign is_mov  = (ir.opc == OPC_MOV);

   // operand slot served by the shared address generator in each phase
   always_comb begin
      case (st)
         ST_LD1, ST_WT1: cur_slot = ir.s1;
         ST_LD2, ST_WT2: cur_slot = ir.s2;
         default:        cur_slot = ir.dst;
      endcase
   end

   qmc_regfile #(.IDXW(RIDX_W), .DW(DW)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (rf_we),
      .waddr   (rf_waddr),
      .wdata   (rf_wdata),
      .raddr_a (cur_slot.ridx),
      .rdata_a (rf_rd_a),
      .raddr_b (ir.s1.ridx),
      .rdata_b (rf_rd_b)
   );

   qmc_agen #(.DW(DW), .AW(AW)) u_agen (
      .slot   (cur_slot),
      .rval   (rf_rd_a),
      .is_mem (ag_mem),
      .addr   (ag_addr),
      .imm    (ag_imm)
   );

   qmc_alu #(.DW(DW), .MUL_VARIANT(MUL_VARIANT)) u_alu (
      .opc (ir.opc),
      .a   (op1),
      .b   (op2),
      .y   (alu_y)
   );

   assign src_val = (cur_slot.mode == AM_REG) ? rf_rd_a : ag_imm;

   // program counter arithmetic
   assign pc_inc = pc + PCW'(1);
   assign br_off = {{(PCW-FLD_W){ir.s1.fld[FLD_W-1]}}, ir.s1.fld};

   always_comb begin
      case (ir.opc)
         OPC_BZ:   pc_next = (rf_rd_b == '0) ? pc + br_off : pc_inc;
         OPC_BREG: pc_next = rf_rd_b[PCW-1:0];
         OPC_CALL: pc_next = pc + br_off;
         default:  pc_next = pc_inc;
      endcase
   end

   // register write-back: data ops to a register, or the call link
   always_comb begin
      rf_we    = 1'b0;
      rf_waddr = ir.dst.ridx;
      rf_wdata = alu_y;
      if (st == ST_EXEC) begin
         if (is_data && ir.dst.mode == AM_REG) begin
            rf_we = 1'b1;
         end else if (ir.opc == OPC_CALL) begin
            rf_we    = 1'b1;
            rf_waddr = RIDX_W'(LINK_REG);
            rf_wdata = DW'(pc_inc);
         end
      end
   end

   // phase sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         pc  <= '0;
         ir  <= '0;
         op1 <= '0;
         op2 <= '0;
      end else begin
         case (st)
            ST_IDLE, ST_HALT: begin
               if (start) begin
                  pc <= '0;
                  st <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (pc >= PCW'(PROG_LEN)) begin
                  st <= ST_HALT;
               end else begin
                  ir <= fetched;
                  st <= opc_is_data(fetched.opc) ? ST_LD1 : ST_EXEC;
               end
            end
            ST_LD1: begin
               if (ag_mem) begin
                  st <= ST_WT1;
               end else begin
                  op1 <= src_val;
                  st  <= is_mov ? ST_EXEC : ST_LD2;
               end
            end
            ST_WT1: begin
               op1 <= dmem_rdata;
               st  <= is_mov ? ST_EXEC : ST_LD2;
            end
            ST_LD2: begin
               if (ag_mem) begin
                  st <= ST_WT2;
               end else begin
                  op2 <= src_val;
                  st  <= ST_EXEC;
               end
            end
            ST_WT2: begin
               op2 <= dmem_rdata;
               st  <= ST_EXEC;
            end
            ST_EXEC: begin
               pc <= pc_next;
               st <= ST_FETCH;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign imem_addr  = pc;
   assign dmem_addr  = ag_addr;
   assign dmem_wdata = alu_y;
   assign dmem_re    = ((st == ST_LD1) || (st == ST_LD2)) && ag_mem;
   assign dmem_we    = (st == ST_EXEC) && is_data && ag_mem;
   assign halted     = (st == ST_IDLE) || (st == ST_HALT);

   AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(dmem_re && dmem_we)); // R7
   AST_READ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_re |=> (st == ST_WT1 || st == ST_WT2)); // R7
   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!dmem_re && !dmem_we)); // R11
   AST_HALT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> (pc >= PCW'(PROG_LEN))); // R11
   AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_EXEC && is_data) |=> (pc == $past(pc) + PCW'(1))); // R3
   AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_EXEC && ir.opc == OPC_CALL) |=> (pc == $past(pc) + $past(br_off))); // R10
endmodule

// File: tb/sim_qmc_core.sv
module sim_qmc_core;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [15:0]  imem_addr;
   logic [63:0]  imem_rdata;
   logic         dmem_re, dmem_we;
   logic [10:0]  dmem_addr;
   logic [31:0]  dmem_wdata;
   logic [31:0]  dmem_rdata = '0;
   logic         halted;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   logic [63:0] rom [16];
   logic [31:0] mem [2048];
   int          nreads, nwrites, ev_n;
   logic [11:0] ev [16];
   bit          both_seen;

   always #10 clk = ~clk;

   qmc_core #(.DW(32), .AW(11), .PCW(16), .PROG_LEN(16), .LINK_REG(15), .MUL_VARIANT(1)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .dmem_re(dmem_re), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
      .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .halted(halted)
   );

   assign imem_rdata = (imem_addr < 16'd16) ? rom[imem_addr[3:0]] : {4'hF, 60'd0};

   always @(posedge clk) begin
      if (dmem_re && dmem_we) both_seen = 1'b1;
      if (dmem_re) begin
         dmem_rdata <= mem[dmem_addr];
         nreads = nreads + 1;
         if (ev_n < 16) begin ev[ev_n] = {1'b0, dmem_addr}; ev_n = ev_n + 1; end
      end
      if (dmem_we) begin
         mem[dmem_addr] <= dmem_wdata;
         nwrites = nwrites + 1;
         if (ev_n < 16) begin ev[ev_n] = {1'b1, dmem_addr}; ev_n = ev_n + 1; end
      end
   end

   function automatic logic [19:0] sl(logic [2:0] m, logic [3:0] r, int v);
      return {m, r, v[12:0]};
   endfunction

   function automatic logic [63:0] ins(logic [3:0] op, logic [19:0] d, logic [19:0] a, logic [19:0] b);
      return {op, d, a, b};
   endfunction

   localparam logic [19:0] Z = 20'd0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_rom;
      for (int i = 0; i < 16; i++) rom[i] = {4'hF, 60'd0};
   endtask

   task automatic clear_counts;
      nreads = 0; nwrites = 0; ev_n = 0; both_seen = 1'b0;
   endtask

   task automatic run_prog;
      @(negedge clk);
      clear_counts();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!halted) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 halted after reset", 32'(halted), 32'd1);
      repeat (4) begin
         @(negedge clk);
         chk("R1 no access before start", {30'd0, dmem_re, dmem_we}, 32'd0);
      end
   endtask

   task automatic t_expression;
      clear_rom();
      mem[100] = 7; mem[104] = 2; mem[108] = 6;
      rom[0] = ins(4'd3, sl(1,1,0), sl(2,0,100), Z);
      rom[1] = ins(4'd3, sl(1,2,0), sl(2,0,104), Z);
      rom[2] = ins(4'd3, sl(1,3,0), sl(2,0,108), Z);
      rom[3] = ins(4'd0, sl(1,4,0), sl(1,1,0), sl(1,2,0));
      rom[4] = ins(4'd0, sl(1,2,0), sl(1,2,0), sl(1,3,0));
      rom[5] = ins(4'd1, sl(1,4,0), sl(1,4,0), sl(1,2,0));
      rom[6] = ins(4'd0, sl(1,1,0), sl(1,1,0), sl(1,3,0));
      rom[7] = ins(4'd1, sl(2,0,100), sl(1,4,0), sl(1,1,0));
      rom[8] = ins(4'd0, sl(2,0,101), sl(2,0,100), sl(2,0,104));
      run_prog();
      chk("R13 R3 x*y+y*z+x*z", mem[100], 32'd68);
      chk("R5 memory-to-memory product", mem[101], 32'd136);
   endtask

   task automatic t_wrap;
      clear_rom();
      rom[0] = ins(4'd3, sl(1,1,0), sl(0,0,-1), Z);
      rom[1] = ins(4'd0, sl(2,0,20), sl(1,1,0), sl(1,1,0));
      rom[2] = ins(4'd1, sl(2,0,21), sl(1,1,0), sl(0,0,2));
      rom[3] = ins(4'd2, sl(2,0,22), sl(0,0,0), sl(0,0,1));
      rom[4] = ins(4'd3, sl(2,0,23), sl(0,0,-4096), Z);
      rom[5] = ins(4'd0, sl(2,0,24), sl(0,0,-3), sl(0,0,7));
      run_prog();
      chk("R3 product low word", mem[20], 32'd1);
      chk("R3 add wraps", mem[21], 32'd1);
      chk("R3 sub wraps", mem[22], 32'hFFFF_FFFF);
      chk("R4 immediate sign extends", mem[23], 32'hFFFF_F000);
      chk("R3 signed product", mem[24], 32'hFFFF_FFEB);
   endtask

   task automatic t_modes;
      clear_rom();
      mem[205] = 32'h55;
      rom[0] = ins(4'd3, sl(1,1,0), sl(0,0,200), Z);
      rom[1] = ins(4'd3, sl(2,0,10), sl(4,1,5), Z);
      rom[2] = ins(4'd3, sl(4,1,-3), sl(0,0,9), Z);
      rom[3] = ins(4'd3, sl(3,1,0), sl(0,0,7), Z);
      rom[4] = ins(4'd3, sl(2,0,11), sl(3,1,0), Z);
      rom[5] = ins(4'd1, sl(2,0,12), sl(5,1,30), sl(0,0,1));
      run_prog();
      chk("R4 indexed source", mem[10], 32'h55);
      chk("R5 indexed negative dest", mem[197], 32'd9);
      chk("R5 indirect dest", mem[200], 32'd7);
      chk("R4 indirect source", mem[11], 32'd7);
      chk("R4 mode 5 acts as immediate", mem[12], 32'd31);
   endtask

   task automatic t_discard;
      clear_rom();
      mem[300] = 32'hAB;
      rom[0] = ins(4'd3, sl(0,0,300), sl(0,0,5), Z);
      rom[1] = ins(4'd1, sl(6,0,300), sl(0,0,6), sl(0,0,1));
      run_prog();
      chk("R5 discarded dest writes nothing", 32'(nwrites), 32'd0);
      chk("R5 memory untouched", mem[300], 32'hAB);
   endtask

   task automatic t_order;
      clear_rom();
      mem[51] = 3; mem[52] = 4;
      rom[0] = ins(4'd2, sl(2,0,50), sl(2,0,51), sl(2,0,52));
      run_prog();
      chk("R7 access count", 32'(ev_n), 32'd3);
      chk("R7 first source-1 read", 32'(ev[0]), {20'd0, 1'b0, 11'd51});
      chk("R7 then source-2 read", 32'(ev[1]), {20'd0, 1'b0, 11'd52});
      chk("R7 then write", 32'(ev[2]), {20'd0, 1'b1, 11'd50});
      chk("R7 difference", mem[50], 32'hFFFF_FFFF);
      chk("R7 no read with write", 32'(both_seen), 32'd0);
   endtask

   task automatic t_branch_zero;
      clear_rom();
      rom[0] = ins(4'd3, sl(1,2,0), sl(0,0,0), Z);
      rom[1] = ins(4'd4, Z, sl(0,2,3), Z);
      rom[2] = ins(4'd3, sl(2,0,30), sl(0,0,1), Z);
      rom[3] = ins(4'd3, sl(2,0,31), sl(0,0,1), Z);
      rom[4] = ins(4'd3, sl(1,3,0), sl(0,0,1), Z);
      rom[5] = ins(4'd4, Z, sl(0,3,4), Z);
      rom[6] = ins(4'd3, sl(2,0,32), sl(0,0,2), Z);
      run_prog();
      chk("R8 taken skips", mem[30], 32'd0);
      chk("R8 taken skips second", mem[31], 32'd0);
      chk("R8 not taken falls through", mem[32], 32'd2);
   endtask

   task automatic t_call;
      clear_rom();
      rom[0] = ins(4'd6, Z, sl(0,0,4), Z);
      rom[1] = ins(4'd3, sl(2,0,61), sl(1,15,0), Z);
      rom[2] = ins(4'd3, sl(1,4,0), sl(0,0,100), Z);
      rom[3] = ins(4'd5, Z, sl(0,4,0), Z);
      rom[4] = ins(4'd3, sl(2,0,60), sl(0,0,11), Z);
      rom[5] = ins(4'd5, Z, sl(0,15,0), Z);
      run_prog();
      chk("R10 call target ran", mem[60], 32'd11);
      chk("R10 R9 link value and return", mem[61], 32'd1);
      chk("R11 halted after jump beyond", 32'(halted), 32'd1);
   endtask

   task automatic t_wrap_halt;
      clear_rom();
      rom[0] = ins(4'd3, sl(1,0,0), sl(0,0,0), Z);
      rom[1] = ins(4'd4, Z, sl(0,0,-5), Z);
      rom[2] = ins(4'd3, sl(2,0,70), sl(0,0,1), Z);
      @(negedge clk);
      clear_counts();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2 fetch from zero", 32'(imem_addr), 32'd0);
      chk("R2 running", 32'(halted), 32'd0);
      while (!halted) @(negedge clk);
      chk("R11 wrapped target stops", mem[70], 32'd0);
      begin
         int r0, w0;
         r0 = nreads; w0 = nwrites;
         repeat (6) @(negedge clk);
         chk("R11 stays halted", 32'(halted), 32'd1);
         chk("R11 quiet while halted", 32'(nreads + nwrites), 32'(r0 + w0));
      end
   endtask

   task automatic t_undefined;
      clear_rom();
      rom[0] = ins(4'd7, sl(2,0,80), sl(2,0,81), sl(2,0,82));
      rom[1] = ins(4'd3, sl(2,0,83), sl(0,0,5), sl(2,0,84));
      run_prog();
      chk("R12 R6 no reads", 32'(nreads), 32'd0);
      chk("R12 no write from undefined", mem[80], 32'd0);
      chk("R6 move result", mem[83], 32'd5);
      chk("R12 single write", 32'(nwrites), 32'd1);
   endtask

   initial begin
      for (int i = 0; i < 2048; i++) mem[i] = '0;
      for (int i = 0; i < 16; i++) ev[i] = '0;
      clear_rom();
      clear_counts();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_expression();
      t_wrap();
      t_modes();
      t_discard();
      t_order();
      t_branch_zero();
      t_call();
      t_wrap_halt();
      t_undefined();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R11 actual=running expected=halted");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule